// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a linked-by-position list of segment descriptors held in memory and hands each described buffer to a downstream data fetcher. A job begins when `start` is pulsed with a list base address and the expected total byte count. The walker reads every 8-byte descriptor through a single-outstanding word read port. The first word of a descriptor carries the byte count in bits 30:0 and a final-entry flag in bit 31. The second word carries the buffer address.

Each descriptor with a nonzero count becomes one segment on a valid/ready output. The walker fetches nothing further until that segment has been accepted, so segments leave in list order. A running sum of all counts is compared with the programmed total once the final entry has been handled. The job ends with a one-cycle `done` pulse, and `err` is raised in that same cycle when the job failed. A job fails on a misaligned base, on a list that reaches its entry cap without a final flag, or on a sum that does not match the total.

Top module: `sg_desc_walker`

## Requirements
- R1: While and after a synchronous reset, `busy`, `done`, `err`, `mem_req_valid` and `seg_valid` are all low.
- R2: Descriptor k of a list at base B is read as two word requests, first at address B+8k (count word) and then at B+8k+4 (address word). All requests are word aligned.
- R3: A descriptor with nonzero count yields one segment whose `seg_addr` is the address word and whose `seg_len` is bits 30:0 of the count word. `seg_addr` and `seg_len` stay stable while `seg_valid` is high and `seg_ready` is low.
- R4: A count word with bit 31 set ends the walk, and no later descriptor is read. If the sum matches the total, `done` pulses with `err` low.
- R5: A descriptor whose count bits 30:0 are zero issues no segment, and the walk continues with the next descriptor.
- R6: No memory request is presented while a segment is waiting on the output. The next descriptor read starts only after the current segment is accepted.
- R7: A list holds at most MAX_DESC entries (default 32). If entry MAX_DESC-1 lacks the final flag, the job ends with `done` and `err` high, and no further entry is read.
- R8: When the sum of all counts differs from `total_len`, the job ends with `done` and `err` high after the final entry has been handled.
- R9: A `start` with `list_base[1:0]` nonzero produces `done` and `err` one cycle later, with no memory request and no `busy`.
- R10: A `start` pulse while `busy` is high is ignored. The active job finishes on its own list, and exactly one `done` is produced.
- R11: `busy` is high from the cycle after an accepted start until the `done` cycle. `done` lasts exactly one cycle, and `err` is only high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a job (sampled while idle) |
| list_base | input | ADDR_W | Byte address of the first descriptor |
| total_len | input | TOT_W | Expected sum of all segment counts |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Job failed, valid with done |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered downstream |
| seg_ready | input | 1 | Downstream accepts the segment |
| seg_addr | output | ADDR_W | Segment buffer address |
| seg_len | output | 31 | Segment byte count |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses and totals, and a cap of 32 entries. With these values a list that runs to the cap, and one that is one entry longer than any legal list, both complete in a few hundred cycles. The full-length legal list and the overflow case therefore run at their real size rather than at a scaled-down cap. Throttling patterns on `mem_req_ready` and `seg_ready` exercise the hold-while-stalled and fetch-after-accept ordering under backpressure.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CNT_W    = 31;
  localparam int unsigned FINAL_B  = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CNT,
    ST_WT_CNT,
    ST_RD_PTR,
    ST_WT_PTR,
    ST_SEG
  } sgw_state_e;
endpackage

// File: rtl/sgw_len_acc.sv
module sgw_len_acc #(
  parameter int unsigned CNT_W = 31,
  parameter int unsigned TOT_W = 32,
  parameter int unsigned SUM_W = 37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [TOT_W-1:0] tot_in,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  output logic             match
);
  logic [SUM_W-1:0] sum_q;
  logic [TOT_W-1:0] tot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      tot_q <= '0;
    end else if (clr) begin
      sum_q <= '0;
      tot_q <= tot_in;
    end else if (add_en) begin
      sum_q <= sum_q + SUM_W'(add_val);
    end
  end

  assign match = (sum_q == SUM_W'(tot_q));

  // R8: the running sum never shrinks within a job
  a_r8_sum_grows: assert property (@(posedge clk) disable iff (rst)
    (!clr && add_en) |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/sgw_seg_slot.sv
module sgw_seg_slot #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_len,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] len,
  output logic          taken
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      len   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      len   <= ld_len;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign taken = valid && ready;

  // R3: an offered segment is held unchanged until accepted
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(len)));
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TOT_W    = 32,
  parameter int unsigned MAX_DESC = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         list_base,
  input  logic [TOT_W-1:0]          total_len,
  output logic                      busy,
  output logic                      done,
  output logic                      err,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [sgw_pkg::WORD_W-1:0] mem_rsp_data,
  output logic                      seg_valid,
  input  logic                      seg_ready,
  output logic [ADDR_W-1:0]         seg_addr,
  output logic [sgw_pkg::CNT_W-1:0] seg_len
);
  import sgw_pkg::*;

  localparam int unsigned IDX_W  = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam int unsigned RAW_W  = CNT_W + IDX_W + 1;
  localparam int unsigned SUM_W  = (RAW_W > TOT_W) ? RAW_W : TOT_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DESC - 1);
  localparam logic [ADDR_W-1:0] LIST_SPAN = ADDR_W'(MAX_DESC * 8);

  sgw_state_e          state_q;
  logic [ADDR_W-1:0]   base_q;
  logic [ADDR_W-1:0]   rd_addr_q;
  logic [IDX_W-1:0]    idx_q;
  logic [WORD_W-1:0]   cnt_word_q;
  logic                done_q;
  logic                err_q;

  logic                aligned;
  logic                accept;
  logic                rsp_ptr;
  logic                cnt_zero;
  logic                step;
  logic                at_cap;
  logic                slot_load;
  logic                seg_taken;
  logic                sum_match;

  assign aligned   = (list_base[1:0] == 2'b00);
  assign accept    = (state_q == ST_IDLE) && start && aligned;
  assign rsp_ptr   = (state_q == ST_WT_PTR) && mem_rsp_valid;
  assign cnt_zero  = (cnt_word_q[CNT_W-1:0] == '0);
  assign slot_load = rsp_ptr && !cnt_zero;
  assign step      = (rsp_ptr && cnt_zero) || ((state_q == ST_SEG) && seg_taken);
  assign at_cap    = (idx_q == LAST_IDX);

  sgw_len_acc #(
    .CNT_W (CNT_W),
    .TOT_W (TOT_W),
    .SUM_W (SUM_W)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .tot_in  (total_len),
    .add_en  (rsp_ptr),
    .add_val (cnt_word_q[CNT_W-1:0]),
    .match   (sum_match)
  );

  sgw_seg_slot #(
    .AW (ADDR_W),
    .CW (CNT_W)
  ) u_slot (
    .clk     (clk),
    .rst     (rst),
    .load    (slot_load),
    .ld_addr (mem_rsp_data[ADDR_W-1:0]),
    .ld_len  (cnt_word_q[CNT_W-1:0]),
    .ready   (seg_ready),
    .valid   (seg_valid),
    .addr    (seg_addr),
    .len     (seg_len),
    .taken   (seg_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      rd_addr_q  <= '0;
      idx_q      <= '0;
      cnt_word_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start && !aligned) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (accept) begin
            base_q    <= list_base;
            rd_addr_q <= list_base;
            idx_q     <= '0;
            state_q   <= ST_RD_CNT;
          end
        end
        ST_RD_CNT: if (mem_req_ready) state_q <= ST_WT_CNT;
        ST_WT_CNT: begin
          if (mem_rsp_valid) begin
            cnt_word_q <= mem_rsp_data;
            rd_addr_q  <= rd_addr_q + ADDR_W'(4);
            state_q    <= ST_RD_PTR;
          end
        end
        ST_RD_PTR: if (mem_req_ready) state_q <= ST_WT_PTR;
        ST_WT_PTR: if (slot_load) state_q <= ST_SEG;
        ST_SEG:    ;
        default:   state_q <= ST_IDLE;
      endcase

      if (step) begin
        if (cnt_word_q[FINAL_B]) begin
          done_q  <= 1'b1;
          err_q   <= !sum_match;
          state_q <= ST_IDLE;
        end else if (at_cap) begin
          done_q  <= 1'b1;
          err_q   <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          idx_q     <= idx_q + IDX_W'(1);
          rd_addr_q <= rd_addr_q + ADDR_W'(4);
          state_q   <= ST_RD_CNT;
        end
      end
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign err           = err_q;
  assign mem_req_valid = (state_q == ST_RD_CNT) || (state_q == ST_RD_PTR);
  assign mem_req_addr  = rd_addr_q;

  // R6: fetching and an unaccepted segment never overlap
  a_r6_no_fetch_while_seg: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_valid && seg_valid));
  // R2: every descriptor read is word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  // R7: reads never go beyond the capped list
  a_r7_within_cap: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> ((mem_req_addr - base_q) < LIST_SPAN));
  // R5: zero-count descriptors never reach the output
  a_r5_no_empty_seg: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len != '0));
  // R11: done is a single-cycle pulse, err only with done, idle at done
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  a_r11_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: a misaligned base fails at once without becoming busy
  a_r9_misaligned: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (list_base[1:0] != 2'b00)) |=> (done && err && !busy));
endmodule

// File: tb/sg_desc_walker_tb_top.sv
`timescale 1ns/1ps
module sg_desc_walker_tb_top;
  localparam int AW = 32;

  typedef struct packed {
    logic [7:0] nd;
    logic [7:0] zero_at;
    logic [7:0] adj;
    logic       bp;
  } job_t;

  localparam int NJOBS = 7;
  localparam job_t JOBS [NJOBS] = '{
    '{8'd1,  8'd99, 8'd0,   1'b0},
    '{8'd4,  8'd99, 8'd0,   1'b1},
    '{8'd5,  8'd2,  8'd0,   1'b0},
    '{8'd3,  8'd99, 8'd1,   1'b0},
    '{8'd6,  8'd5,  8'd0,   1'b1},
    '{8'd32, 8'd99, 8'd0,   1'b0},
    '{8'd2,  8'd99, 8'd200, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic [31:0] total_len = '0;
  logic busy, done, err;
  logic mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic seg_valid, seg_ready;
  logic [AW-1:0] seg_addr;
  logic [30:0] seg_len;

  always #2 clk = ~clk;

  sg_desc_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .list_base(list_base),
    .total_len(total_len), .busy(busy), .done(done), .err(err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] cyc = '0;
  logic bp_en = 1'b0;
  assign mem_req_ready = bp_en ? cyc[0] : 1'b1;
  assign seg_ready     = bp_en ? (cyc[1:0] == 2'b11) : 1'b1;

  logic [31:0] seg_a [0:511];
  logic [30:0] seg_l [0:511];
  logic [31:0] rd_log [0:1023];
  int nseg = 0, nrd = 0, ndone = 0, noverlap = 0;
  logic last_err = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[11:2]];
    if (!rst) begin
      if (mem_req_valid && mem_req_ready) begin
        if (nrd < 1024) rd_log[nrd] <= mem_req_addr;
        nrd <= nrd + 1;
      end
      if (seg_valid && seg_ready) begin
        if (nseg < 512) begin
          seg_a[nseg] <= seg_addr;
          seg_l[nseg] <= seg_len;
        end
        nseg <= nseg + 1;
      end
      if (done) begin
        ndone <= ndone + 1;
        last_err <= err;
      end
      if (mem_req_valid && seg_valid) noverlap <= noverlap + 1;
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] d_cnt(input int j, input int k);
    return 32'(16 * (k + 1) + j + 3);
  endfunction
  function automatic logic [31:0] d_ptr(input int j, input int k);
    return 32'h8000_0000 | (32'(j) << 16) | (32'(k) << 8);
  endfunction

  task automatic put_desc(input logic [31:0] base, input int k,
                          input logic [31:0] cnt, input bit fin, input logic [31:0] ptr);
    logic [31:0] a;
    a = base + 32'(8 * k);
    mem[a[11:2]]     = cnt | (fin ? 32'h8000_0000 : 32'h0);
    mem[a[11:2] + 1] = ptr;
  endtask

  task automatic launch(input logic [31:0] base, input logic [31:0] tot);
    @(negedge clk);
    list_base = base;
    total_len = tot;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    int s0, r0, d0;
    logic [31:0] base, sum;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({busy, done, err, mem_req_valid, seg_valid} == 5'b0, "R1 reset outputs",
        {busy, done, err, mem_req_valid, seg_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, mem_req_valid, seg_valid} == 5'b0, "R1 idle after reset",
        {busy, done, err, mem_req_valid, seg_valid}, 0);

    // table-driven jobs: R2 R3 R4 R5 R8 R6 R11
    base = 32'h200;
    for (int j = 0; j < NJOBS; j++) begin
      int nd, za, expseg, si;
      nd = int'(JOBS[j].nd);
      za = int'(JOBS[j].zero_at);
      sum = '0;
      for (int k = 0; k < nd; k++) begin
        logic [31:0] c;
        c = (k == za) ? 32'h0 : d_cnt(j, k);
        sum += c;
        put_desc(base, k, c, k == nd - 1, d_ptr(j, k));
      end
      expseg = (za < nd) ? nd - 1 : nd;
      bp_en = JOBS[j].bp;
      s0 = nseg; r0 = nrd; d0 = ndone;
      launch(base, sum + 32'(JOBS[j].adj));
      chk(busy == 1'b1, "R11 busy after start", busy, 1);
      wait_done(seen);
      chk(seen, "R11 done seen", seen, 1);
      chk(err == (JOBS[j].adj != 0), JOBS[j].adj != 0 ? "R8 mismatch err" : "R4 clean end",
          err, JOBS[j].adj != 0);
      repeat (12) @(negedge clk);
      chk(ndone - d0 == 1, "R11 single done", ndone - d0, 1);
      chk(nrd - r0 == 2 * nd, "R4 reads stop at final", nrd - r0, 2 * nd);
      for (int q = 0; q < 2 * nd; q++)
        chk(rd_log[r0 + q] == base + 32'(4 * q), "R2 read order", rd_log[r0 + q], base + 32'(4 * q));
      chk(nseg - s0 == expseg, "R5 segment count", nseg - s0, expseg);
      si = s0;
      for (int k = 0; k < nd; k++) begin
        if (k != za) begin
          chk(seg_a[si] == d_ptr(j, k) && seg_l[si] == d_cnt(j, k)[30:0], "R3 segment content",
              {seg_a[si], 1'b0, seg_l[si]}, {d_ptr(j, k), 1'b0, d_cnt(j, k)[30:0]});
          si++;
        end
      end
    end
    bp_en = 1'b0;

    // R7: 33 entries without a final flag
    for (int k = 0; k < 33; k++) put_desc(base, k, 32'd8, 1'b0, d_ptr(9, k));
    s0 = nseg; r0 = nrd; d0 = ndone;
    launch(base, 32'd256);
    wait_done(seen);
    chk(seen && err, "R7 cap error", {seen, err}, 2'b11);
    repeat (12) @(negedge clk);
    chk(nrd - r0 == 64, "R7 no read past cap", nrd - r0, 64);
    chk(nseg - s0 == 32, "R7 segments before cap", nseg - s0, 32);

    // R9: misaligned base
    r0 = nrd; d0 = ndone;
    launch(32'h202, 32'd0);
    chk(done && err && !busy, "R9 immediate error", {done, err, busy}, 3'b110);
    repeat (6) @(negedge clk);
    chk(nrd == r0 && ndone - d0 == 1, "R9 no reads", nrd - r0, 0);

    // R10: start while busy is ignored
    for (int k = 0; k < 4; k++) put_desc(32'h200, k, d_cnt(1, k), k == 3, d_ptr(1, k));
    for (int k = 0; k < 2; k++) put_desc(32'h600, k, 32'd4, k == 1, d_ptr(7, k));
    bp_en = 1'b1;
    s0 = nseg; r0 = nrd; d0 = ndone;
    sum = d_cnt(1, 0) + d_cnt(1, 1) + d_cnt(1, 2) + d_cnt(1, 3);
    launch(32'h200, sum);
    repeat (5) @(negedge clk);
    list_base = 32'h600; total_len = 32'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk(seen && !err, "R10 first job completes", {seen, err}, 2'b10);
    repeat (20) @(negedge clk);
    chk(ndone - d0 == 1, "R10 one done", ndone - d0, 1);
    chk(nrd - r0 == 8, "R10 reads of first list only", nrd - r0, 8);
    chk(seg_a[s0 + 3] == d_ptr(1, 3), "R10 segments from first list", seg_a[s0 + 3], d_ptr(1, 3));
    bp_en = 1'b0;

    // R6: overlap monitor over whole run
    chk(noverlap == 0, "R6 no fetch during segment", noverlap, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule